// File: doc/BRIEF.md
# Serial Response Poll and Recovery Controller

This block is the receive half of a single-wire serial link master. Once the transmitter has sent a command, the controller pads the link with idle clocks. It then watches the active-low data line for a start bit and decodes the reply: a slave id, a two-bit response tag, an optional data field and a four-bit check code. The block then decides how to recover. A corrupted reply is answered with an error poll. A busy slave is polled again for data. A slave that stays busy too long is sent a terminate command. Every operation ends with a burst of priming clocks and a one-cycle completion pulse that carries a status code and the read data.

The controller advances one link clock per core clock. It does not drive the pins. It marks the idle-padding cycles on `pad_o`, and it hands each poll or terminate frame to an external serialiser through `tx_req_o`. That serialiser reports back on `tx_done_i` when the frame has gone out.

Top module: `resp_poll_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `tx_req_o` and `pad_o` are 0, and `status_o` and `rdata_o` are 0.
- R2: Both after `start_i` and after each `tx_done_i`, `pad_o` is high for exactly 16 cycles before the line is sampled.
- R3: The line is registered once and inverted, so a low level is a decoded 1. The first decoded 1 is the start bit. Up to 1000 samples are examined, and a start bit on the 1000th sample is accepted. If no start bit arrives, the operation ends with status 4.
- R4: After the start bit the block reads 2 id bits and then 2 tag bits, most significant bit first. The tag codes are ACK=0, BUSY=1, general error=2 and command-check error=3. A valid ACK ends with status 0.
- R5: Data bits (`size_i`×8, most significant bit first) are read only after an ACK tag with a nonzero size. `rdata_o` is right-aligned: the last received byte is in bits [7:0], and bits above the data field are 0. `rdata_o` is 0 after any completion that is not an ACK.
- R6: The check code is x^4+x+1 with zero initial state, computed most significant bit first over the start bit, id, tag and data. The reply is valid when the register also absorbs the 4 received check bits and ends at zero.
- R7: A check failure produces 50 pad cycles and then the 5-bit frame {id, 011}. The 12th consecutive failure, after 11 error polls, ends with status 5 and sends no further poll.
- R8: A BUSY reply produces 50 pad cycles and then the 5-bit frame {id, 010}. Up to 200 of these polls are sent.
- R9: The BUSY reply after the 200th poll produces 50 pad cycles and then the 8-bit frame {id, 111111}. An ACK to that frame ends with status 6. Any other outcome of it ends with status 7.
- R10: A general error reply ends with status 2, and a command-check error reply ends with status 3.
- R11: Every operation ends with 20 pad cycles followed by a single-cycle `done_o`, and `status_o` is valid while `done_o` is high.
- R12: `start_i` pulses while `busy_o` is high are ignored. The id and size latched at the start are kept.
- R13: Frames on `tx_frame_o` are right-aligned with length `tx_len_o`, and `tx_req_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, one link clock per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command has been sent, begin response handling |
| size_i | input | 3 | Expected data bytes (0 to 4) |
| slave_id_i | input | 2 | Target slave id |
| sda_i | input | 1 | Raw data line, active low |
| tx_done_i | input | 1 | Serialiser finished the requested frame |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| status_o | output | 3 | Completion status code |
| rdata_o | output | 32 | Read data, right-aligned |
| tx_req_o | output | 1 | Frame send request pulse |
| tx_frame_o | output | 8 | Frame bits, right-aligned, MSB sent first |
| tx_len_o | output | 4 | Frame length in bits |
| pad_o | output | 1 | Idle padding clock in progress |

## Verification
Start-bit detection and expiry of the response timeout can resolve in the same cycle, when the start bit reaches the register on the very last sample the wait window examines. The bench's slave model counts cycles from the falling edge of the echo padding. It places the start bit once at an offset that lands on the 1000th sample, where the reply must be decoded with status 0 and its data. It places the start bit again one cycle later, where the operation must end with timeout status 4 and zero data. A second overlap is a new `start_i` arriving while a poll sequence is running. Every frame that follows must then still carry the original id.

// File: rtl/prp_pkg.sv
package prp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ECHO, S_WAIT, S_HDR, S_DATA, S_CRC, S_EVAL,
    S_PAD, S_TXREQ, S_TXWAIT, S_PRIME, S_DONE
  } state_e;

  typedef enum logic [1:0] {
    CMD_DPOLL = 2'd0,
    CMD_EPOLL = 2'd1,
    CMD_TERM  = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_OK         = 3'd0,
    ST_ERR_GEN    = 3'd2,
    ST_ERR_CMDCRC = 3'd3,
    ST_TIMEOUT    = 3'd4,
    ST_IOERR      = 3'd5,
    ST_BUSY_TERM  = 3'd6,
    ST_TERM_FAIL  = 3'd7
  } status_e;

  localparam logic [1:0] TAG_ACK  = 2'd0;
  localparam logic [1:0] TAG_BUSY = 2'd1;
  localparam logic [1:0] TAG_ERRG = 2'd2;
  localparam logic [1:0] TAG_ERRC = 2'd3;

  localparam logic [3:0] CRC_POLY = 4'h3;

  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? CRC_POLY : 4'h0);
  endfunction

endpackage

// File: rtl/prp_crc4.sv
module prp_crc4
  import prp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic en_i,
  input  logic bit_i,
  output logic zero_o
);
  logic [3:0] crc_q;

  // init absorbs the start bit (decoded 1) into a zero register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 4'h0;
    else if (init_i) crc_q <= crc4_step(4'h0, 1'b1);
    else if (en_i)   crc_q <= crc4_step(crc_q, bit_i);
  end

  assign zero_o = (crc_q == 4'h0);
endmodule

// File: rtl/prp_rx_path.sv
module prp_rx_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              clr_i,
  input  logic              hdr_en_i,
  input  logic              data_en_i,
  input  logic              crc_en_i,
  output logic              bit_o,
  output logic [3:0]        hdr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              crc_ok_o
);
  logic              bit_q;
  logic [3:0]        hdr_q;
  logic [DATA_W-1:0] data_q;

  // single synchroniser stage, line is active low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= ~sda_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q  <= '0;
      data_q <= '0;
    end else if (clr_i) begin
      hdr_q  <= '0;
      data_q <= '0;
    end else begin
      if (hdr_en_i)  hdr_q  <= {hdr_q[2:0], bit_q};
      if (data_en_i) data_q <= {data_q[DATA_W-2:0], bit_q};
    end
  end

  prp_crc4 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (clr_i),
    .en_i   (crc_en_i),
    .bit_i  (bit_q),
    .zero_o (crc_ok_o)
  );

  assign bit_o  = bit_q;
  assign hdr_o  = hdr_q;
  assign data_o = data_q;
endmodule

// File: rtl/prp_cmd_build.sv
module prp_cmd_build
  import prp_pkg::*;
(
  input  cmd_e       cmd_i,
  input  logic [1:0] id_i,
  output logic [7:0] frame_o,
  output logic [3:0] len_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_DPOLL: begin frame_o = {3'b000, id_i, 3'b010}; len_o = 4'd5; end
      CMD_EPOLL: begin frame_o = {3'b000, id_i, 3'b011}; len_o = 4'd5; end
      CMD_TERM:  begin frame_o = {id_i, 6'b111111};      len_o = 4'd8; end
      default:   begin frame_o = 8'h00;                  len_o = 4'd0; end
    endcase
  end
endmodule

// File: rtl/resp_poll_ctrl.sv
module resp_poll_ctrl
  import prp_pkg::*;
#(
  parameter int MAX_BYTES     = 4,
  parameter int ECHO_CLKS     = 16,
  parameter int START_TMO     = 1000,
  parameter int POLL_PAD      = 50,
  parameter int PRIME_CLKS    = 20,
  parameter int MAX_BUSY      = 200,
  parameter int CRC_RETRY_MAX = 10
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0]     size_i,
  input  logic [1:0]                         slave_id_i,
  input  logic                               sda_i,
  input  logic                               tx_done_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic [2:0]                         status_o,
  output logic [MAX_BYTES*8-1:0]             rdata_o,
  output logic                               tx_req_o,
  output logic [7:0]                         tx_frame_o,
  output logic [3:0]                         tx_len_o,
  output logic                               pad_o
);
  localparam int DATA_W  = MAX_BYTES * 8;
  localparam int SIZE_W  = $clog2(MAX_BYTES + 1);
  localparam int M1      = (START_TMO > POLL_PAD) ? START_TMO : POLL_PAD;
  localparam int M2      = (ECHO_CLKS > PRIME_CLKS) ? ECHO_CLKS : PRIME_CLKS;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int CNT_MAX = (M3 > DATA_W) ? M3 : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1) < SIZE_W + 3 ? SIZE_W + 3 : $clog2(CNT_MAX + 1);
  localparam int BUSY_W  = $clog2(MAX_BUSY + 1);
  localparam int CRCC_W  = $clog2(CRC_RETRY_MAX + 2);

  state_e              state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SIZE_W-1:0]   size_q;
  logic [1:0]          id_q;
  logic                term_q;
  logic [BUSY_W-1:0]   busy_cnt_q;
  logic [CRCC_W-1:0]   crc_cnt_q;
  cmd_e                cmd_q;
  status_e             fin_q;
  logic [2:0]          status_q;
  logic [DATA_W-1:0]   rdata_q;

  logic                rx_bit;
  logic [3:0]          hdr;
  logic [DATA_W-1:0]   rx_data;
  logic                crc_ok;
  logic                rx_clr;
  logic [SIZE_W-1:0]   eff_size;
  logic [CNT_W-1:0]    data_last;
  logic [1:0]          tag_nxt;
  logic [1:0]          hdr_tag;

  assign rx_clr    = (state_q == S_WAIT) && rx_bit;
  assign eff_size  = term_q ? '0 : size_q;
  assign data_last = CNT_W'({eff_size, 3'b000}) - 1'b1;
  assign tag_nxt   = {hdr[0], rx_bit};
  assign hdr_tag   = hdr[1:0];

  prp_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_i),
    .clr_i     (rx_clr),
    .hdr_en_i  (state_q == S_HDR),
    .data_en_i (state_q == S_DATA),
    .crc_en_i  ((state_q == S_HDR) || (state_q == S_DATA) || (state_q == S_CRC)),
    .bit_o     (rx_bit),
    .hdr_o     (hdr),
    .data_o    (rx_data),
    .crc_ok_o  (crc_ok)
  );

  prp_cmd_build u_cmd (
    .cmd_i   (cmd_q),
    .id_i    (id_q),
    .frame_o (tx_frame_o),
    .len_o   (tx_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      size_q     <= '0;
      id_q       <= '0;
      term_q     <= 1'b0;
      busy_cnt_q <= '0;
      crc_cnt_q  <= '0;
      cmd_q      <= CMD_DPOLL;
      fin_q      <= ST_OK;
      status_q   <= '0;
      rdata_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          size_q     <= (size_i > SIZE_W'(MAX_BYTES)) ? SIZE_W'(MAX_BYTES) : size_i;
          id_q       <= slave_id_i;
          term_q     <= 1'b0;
          busy_cnt_q <= '0;
          crc_cnt_q  <= '0;
          rdata_q    <= '0;
          cnt_q      <= '0;
          state_q    <= S_ECHO;
        end
        S_ECHO: begin
          if (cnt_q == CNT_W'(ECHO_CLKS - 1)) begin
            cnt_q   <= '0;
            state_q <= S_WAIT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_WAIT: begin
          if (rx_bit) begin
            cnt_q   <= '0;
            state_q <= S_HDR;
          end else if (cnt_q == CNT_W'(START_TMO - 1)) begin
            cnt_q   <= '0;
            fin_q   <= term_q ? ST_TERM_FAIL : ST_TIMEOUT;
            state_q <= S_PRIME;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_HDR: begin
          if (cnt_q == CNT_W'(3)) begin
            cnt_q   <= '0;
            state_q <= (tag_nxt == TAG_ACK && eff_size != '0) ? S_DATA : S_CRC;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_DATA: begin
          if (cnt_q == data_last) begin
            cnt_q   <= '0;
            state_q <= S_CRC;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_CRC: begin
          if (cnt_q == CNT_W'(3)) begin
            cnt_q   <= '0;
            state_q <= S_EVAL;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_EVAL: begin
          cnt_q <= '0;
          if (!crc_ok) begin
            if (term_q) begin
              fin_q <= ST_TERM_FAIL; state_q <= S_PRIME;
            end else if (crc_cnt_q > CRCC_W'(CRC_RETRY_MAX)) begin
              fin_q <= ST_IOERR; state_q <= S_PRIME;
            end else begin
              crc_cnt_q <= crc_cnt_q + 1'b1;
              cmd_q     <= CMD_EPOLL;
              state_q   <= S_PAD;
            end
          end else begin
            unique case (hdr_tag)
              TAG_ACK: begin
                if (term_q) fin_q <= ST_BUSY_TERM;
                else begin
                  fin_q   <= ST_OK;
                  rdata_q <= rx_data;
                end
                state_q <= S_PRIME;
              end
              TAG_BUSY: begin
                if (term_q) begin
                  fin_q <= ST_TERM_FAIL; state_q <= S_PRIME;
                end else if (busy_cnt_q < BUSY_W'(MAX_BUSY)) begin
                  busy_cnt_q <= busy_cnt_q + 1'b1;
                  cmd_q      <= CMD_DPOLL;
                  state_q    <= S_PAD;
                end else begin
                  term_q  <= 1'b1;
                  cmd_q   <= CMD_TERM;
                  state_q <= S_PAD;
                end
              end
              TAG_ERRG: begin
                fin_q   <= term_q ? ST_TERM_FAIL : ST_ERR_GEN;
                state_q <= S_PRIME;
              end
              default: begin
                fin_q   <= term_q ? ST_TERM_FAIL : ST_ERR_CMDCRC;
                state_q <= S_PRIME;
              end
            endcase
          end
        end
        S_PAD: begin
          if (cnt_q == CNT_W'(POLL_PAD - 1)) begin
            cnt_q   <= '0;
            state_q <= S_TXREQ;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_TXREQ: state_q <= S_TXWAIT;
        S_TXWAIT: if (tx_done_i) begin
          cnt_q   <= '0;
          state_q <= S_ECHO;
        end
        S_PRIME: begin
          if (cnt_q == CNT_W'(PRIME_CLKS - 1)) begin
            cnt_q    <= '0;
            status_q <= fin_q;
            state_q  <= S_DONE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign tx_req_o = (state_q == S_TXREQ);
  assign pad_o    = (state_q == S_ECHO) || (state_q == S_PAD) || (state_q == S_PRIME);
  assign status_o = status_q;
  assign rdata_o  = rdata_q;

  a_r11_done_after_prime: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pad_o));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r13_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);
  a_r8_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= BUSY_W'(MAX_BUSY));
  a_r7_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_cnt_q <= CRCC_W'(CRC_RETRY_MAX + 1));
  a_r5_data_only_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA) |-> (hdr_tag == TAG_ACK));
  a_r3_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> (cnt_q < CNT_W'(START_TMO)));
  a_r9_term_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && term_q) |-> (tx_len_o == 4'd8));
endmodule

// File: tb/resp_poll_ctrl_bench.sv
module resp_poll_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  size = '0;
  logic [1:0]  sid = '0;
  logic        sda = 1'b1;
  logic        tx_done = 1'b0;
  logic        busy, done, tx_req, pad;
  logic [2:0]  status;
  logic [31:0] rdata;
  logic [7:0]  tx_frame;
  logic [3:0]  tx_len;

  always #5 clk = ~clk;

  resp_poll_ctrl u_resp_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size),
    .slave_id_i(sid), .sda_i(sda), .tx_done_i(tx_done),
    .busy_o(busy), .done_o(done), .status_o(status), .rdata_o(rdata),
    .tx_req_o(tx_req), .tx_frame_o(tx_frame), .tx_len_o(tx_len), .pad_o(pad)
  );

  typedef struct { int dly; logic [1:0] tag; int nb; logic [31:0] data; bit bad; } rsp_t;
  typedef struct { logic [2:0] st; logic [31:0] data; string req; } res_t;
  typedef struct { logic [7:0] fr; logic [3:0] len; string req; } txe_t;

  rsp_t rsp_q[$];
  res_t res_q[$];
  txe_t tx_q[$];
  int n_chk = 0, n_fail = 0;
  logic [1:0] cur_id = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] crc_nx(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
  endfunction

  task automatic add_rsp(input int dly, input logic [1:0] tag, input int nb,
                         input logic [31:0] data, input bit bad);
    rsp_t r;
    r.dly = dly; r.tag = tag; r.nb = nb; r.data = data; r.bad = bad;
    rsp_q.push_back(r);
  endtask

  task automatic exp_tx(input int kind, input logic [1:0] id, input string req);
    txe_t t;
    t.req = req;
    if (kind == 0)      begin t.fr = {3'b000, id, 3'b010}; t.len = 4'd5; end
    else if (kind == 1) begin t.fr = {3'b000, id, 3'b011}; t.len = 4'd5; end
    else                begin t.fr = {id, 6'h3f};          t.len = 4'd8; end
    tx_q.push_back(t);
  endtask

  task automatic exp_res(input logic [2:0] st, input logic [31:0] data, input string req);
    res_t r;
    r.st = st; r.data = data; r.req = req;
    res_q.push_back(r);
  endtask

  // slave model: answers after each echo padding window
  initial begin : slave
    bit prev;
    rsp_t r;
    bit fr[$];
    logic [3:0] c;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (prev && !pad && !tx_req && !done && rsp_q.size() > 0) begin
        r = rsp_q.pop_front();
        fr.delete();
        fr.push_back(1'b1);
        fr.push_back(cur_id[1]); fr.push_back(cur_id[0]);
        fr.push_back(r.tag[1]);  fr.push_back(r.tag[0]);
        for (int i = r.nb * 8 - 1; i >= 0; i--) fr.push_back(r.data[i]);
        c = 4'h0;
        foreach (fr[i]) c = crc_nx(c, fr[i]);
        if (r.bad) c[0] = ~c[0];
        for (int i = 3; i >= 0; i--) fr.push_back(c[i]);
        repeat (r.dly) @(negedge clk);
        foreach (fr[i]) begin
          sda = ~fr[i];
          @(negedge clk);
        end
        sda = 1'b1;
      end
      prev = pad;
    end
  end

  // serialiser model
  int txc = 0;
  always @(negedge clk) begin
    tx_done <= (txc == 1);
    if (tx_req) txc <= 4;
    else if (txc != 0) txc <= txc - 1;
  end

  // monitor / scoreboard
  int run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pad) run++;
      else if (run != 0) begin
        if (tx_req)    chk(run == 50, "R8", "pre-poll pad", run, 50);
        else if (done) chk(run == 20, "R11", "prime pad", run, 20);
        else           chk(run == 16, "R2", "echo pad", run, 16);
        run = 0;
      end
      if (tx_req) begin
        if (tx_q.size() == 0) chk(0, "R13", "unexpected tx frame", tx_frame, 0);
        else begin
          txe_t t;
          t = tx_q.pop_front();
          chk(tx_frame == t.fr, t.req, "tx frame", tx_frame, t.fr);
          chk(tx_len == t.len, t.req, "tx len", tx_len, t.len);
        end
      end
      if (done) begin
        if (res_q.size() == 0) chk(0, "R11", "unexpected done", status, 0);
        else begin
          res_t e;
          e = res_q.pop_front();
          chk(status == e.st, e.req, "status", status, e.st);
          chk(rdata == e.data, e.req, "rdata", rdata, e.data);
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] id, input logic [2:0] sz, input bit glitch);
    cur_id = id;
    @(negedge clk);
    start = 1'b1; sid = id; size = sz;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (30) @(negedge clk);
      start = 1'b1; sid = ~id; size = 3'd4;
      @(negedge clk);
      start = 1'b0;
    end
    wait (res_q.size() == 0);
    repeat (5) @(negedge clk);
    chk(tx_q.size() == 0, "R13", "unsent expected frames", tx_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(tx_req == 0, "R1", "tx_req", tx_req, 0);
    chk(pad == 0, "R1", "pad", pad, 0);
    chk(status == 0, "R1", "status", status, 0);
    chk(rdata == 0, "R1", "rdata", rdata, 0);

    // R4 R5 R6: four-byte ACK
    add_rsp(3, 2'd0, 4, 32'hA5C3_1E70, 0);
    exp_res(3'd0, 32'hA5C3_1E70, "R5");
    run_op(2'd2, 3'd4, 0);

    // R5 single byte, upper bits zero
    add_rsp(0, 2'd0, 1, 32'h0000_005A, 0);
    exp_res(3'd0, 32'h0000_005A, "R5");
    run_op(2'd1, 3'd1, 0);

    // R5 zero size: no data bits
    add_rsp(7, 2'd0, 0, 32'h0, 0);
    exp_res(3'd0, 32'h0, "R4");
    run_op(2'd3, 3'd0, 0);

    // R10 error tags
    add_rsp(2, 2'd2, 0, 32'h0, 0);
    exp_res(3'd2, 32'h0, "R10");
    run_op(2'd0, 3'd2, 0);
    add_rsp(2, 2'd3, 0, 32'h0, 0);
    exp_res(3'd3, 32'h0, "R10");
    run_op(2'd1, 3'd2, 0);

    // R8 busy twice then data; R12 start during operation ignored
    add_rsp(1, 2'd1, 0, 32'h0, 0);
    add_rsp(1, 2'd1, 0, 32'h0, 0);
    add_rsp(1, 2'd0, 2, 32'h0000_BEEF, 0);
    exp_tx(0, 2'd2, "R12");
    exp_tx(0, 2'd2, "R8");
    exp_res(3'd0, 32'h0000_BEEF, "R12");
    run_op(2'd2, 3'd2, 1);

    // R7 three check failures then good reply
    for (int i = 0; i < 3; i++) begin
      add_rsp(0, 2'd0, 4, 32'h1234_5678, 1);
      exp_tx(1, 2'd1, "R7");
    end
    add_rsp(0, 2'd0, 4, 32'h1234_5678, 0);
    exp_res(3'd0, 32'h1234_5678, "R6");
    run_op(2'd1, 3'd4, 0);

    // R7 retries exhausted: 11 error polls, status 5
    for (int i = 0; i < 12; i++) add_rsp(0, 2'd0, 1, 32'h0000_00C3, 1);
    for (int i = 0; i < 11; i++) exp_tx(1, 2'd3, "R7");
    exp_res(3'd5, 32'h0, "R7");
    run_op(2'd3, 3'd1, 0);

    // R9 busy escalation, terminate acknowledged
    for (int i = 0; i < 201; i++) add_rsp(0, 2'd1, 0, 32'h0, 0);
    add_rsp(0, 2'd0, 0, 32'h0, 0);
    for (int i = 0; i < 200; i++) exp_tx(0, 2'd1, "R8");
    exp_tx(2, 2'd1, "R9");
    exp_res(3'd6, 32'h0, "R9");
    run_op(2'd1, 3'd2, 0);

    // R9 terminate answered with error
    for (int i = 0; i < 201; i++) add_rsp(0, 2'd1, 0, 32'h0, 0);
    add_rsp(0, 2'd2, 0, 32'h0, 0);
    for (int i = 0; i < 200; i++) exp_tx(0, 2'd2, "R8");
    exp_tx(2, 2'd2, "R9");
    exp_res(3'd7, 32'h0, "R9");
    run_op(2'd2, 3'd1, 0);

    // R3 no reply: timeout
    exp_res(3'd4, 32'h0, "R3");
    run_op(2'd0, 3'd1, 0);

    // R3 start bit on last examined sample
    add_rsp(998, 2'd0, 1, 32'h0000_0096, 0);
    exp_res(3'd0, 32'h0000_0096, "R3");
    run_op(2'd0, 3'd1, 0);

    // R3 start bit one sample too late
    add_rsp(999, 2'd0, 1, 32'h0000_0096, 0);
    exp_res(3'd4, 32'h0, "R3");
    run_op(2'd0, 3'd1, 0);
    repeat (40) @(negedge clk);

    chk(rsp_q.size() == 0, "R2", "unused slave replies", rsp_q.size(), 0);
    chk(busy == 0, "R11", "idle after ops", busy, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule